// File: doc/BRIEF.md
# Serial Port FIFO Bus Interface

This block sits between a processor or DMA engine and the data path of a synchronous serial port. One 32-bit data location is shared by both directions. A bus write to it pushes one word into a 16-entry transmit queue, and a bus read from it pops one word from a 16-entry receive queue. Every bus access moves exactly one entry. The serializer drains the transmit queue through a pop strobe, and the deserializer fills the receive queue through a push strobe.

A programmable sample size from 4 to 32 bits limits the payload. Bits at and above the sample size are stripped when a word is written, and they read back as zero when a word is read. For each queue, a fill level is compared against a programmable watermark. The result drives an interrupt line and a DMA request line, and each line has its own enable. Status outputs give the fill levels, the not-full and not-empty indications, and two sticky error flags: one for a write that was refused and one for a read from an empty queue.

Top module: `ssp_fifo_bus_if`

## Requirements
- R1: Each queue holds at most 16 words. The transmit and receive levels run from 0 to 16. The not-full and not-empty outputs follow the level, and all of them update on the clock edge that accepts a push or a pop.
- R2: A bus write with room available stores the written word with every bit at position `cfg_sample_bits` and above cleared. Sample-size values below 4 act as 4, and values above 32 act as 32.
- R3: In the same cycle as `bus_rd_en`, `bus_rdata` shows the oldest received word with bits at and above the current sample size forced to zero. The read pops that word at the clock edge.
- R4: A bus write while the transmit queue holds 16 words is discarded and leaves the level at 16. It sets `tx_overrun`, which stays set until an `err_clr` pulse.
- R5: A bus read while the receive queue is empty returns zero and leaves the level at 0. It sets `rx_underrun`, which stays set until an `err_clr` pulse.
- R6: The transmit watermark is hit while the transmit level is less than or equal to the threshold. Threshold code 0 means 16, and codes 1 to 15 are taken literally. `tx_irq` equals hit AND `cfg_tx_irq_en`, and `tx_dma_req` equals hit AND `cfg_tx_dma_en`.
- R7: The receive watermark is hit while the receive level is greater than or equal to the threshold, using the same threshold coding as R6. `rx_irq` and `rx_dma_req` are gated by their own enables.
- R8: Both queues are first-in first-out. A deserializer push into a full receive queue is dropped. A serializer pop of an empty transmit queue does nothing and shows zero. A push and a pop in the same cycle leave the level unchanged.
- R9: After reset both queues are empty, both error flags are clear, and `bus_rdata` and `ser_data` are zero.
- R10: A bus read and a bus write in the same cycle act independently, each on its own queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe at the data location |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe at the data location |
| bus_rdata | output | 32 | Masked head of the receive queue |
| cfg_sample_bits | input | 6 | Sample size in bits (4 to 32) |
| cfg_tx_thresh | input | 4 | Transmit watermark code (0 means 16) |
| cfg_rx_thresh | input | 4 | Receive watermark code (0 means 16) |
| cfg_tx_irq_en | input | 1 | Transmit interrupt enable |
| cfg_tx_dma_en | input | 1 | Transmit DMA request enable |
| cfg_rx_irq_en | input | 1 | Receive interrupt enable |
| cfg_rx_dma_en | input | 1 | Receive DMA request enable |
| err_clr | input | 1 | Clears both sticky error flags |
| ser_pop | input | 1 | Serializer takes one transmit word |
| ser_data | output | 32 | Oldest transmit word |
| des_push | input | 1 | Deserializer delivers one word |
| des_data | input | 32 | Received word |
| tx_irq | output | 1 | Transmit refill interrupt |
| tx_dma_req | output | 1 | Transmit refill DMA request |
| rx_irq | output | 1 | Receive drain interrupt |
| rx_dma_req | output | 1 | Receive drain DMA request |
| tx_level | output | 5 | Transmit fill level |
| rx_level | output | 5 | Receive fill level |
| tx_not_full | output | 1 | Transmit queue has room |
| tx_not_empty | output | 1 | Transmit queue holds data |
| rx_not_full | output | 1 | Receive queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| tx_overrun | output | 1 | Sticky: write refused while full |
| rx_underrun | output | 1 | Sticky: read while empty |

## Verification
A pointer or count error shows up on the very next read or serializer pop. The word that appears is out of order, repeated, or missing, and a level output disagrees with the number of accepted pushes minus pops one edge after the stimulus. A masking fault is visible on the same cycle as the access, either in `ser_data` or in `bus_rdata`. A wrong watermark comparison shows up as a request line that is wrong at exactly the level where the threshold boundary is crossed. For that reason the bench steps the levels through each threshold one word at a time.

// File: rtl/ssp_fifo_pkg.sv
`timescale 1ns/1ps
package ssp_fifo_pkg;
   // Direction of a watermark comparison.
   typedef enum logic {
      WM_REFILL = 1'b0,   // hit while level <= threshold
      WM_DRAIN  = 1'b1    // hit while level >= threshold
   } wm_dir_e;

   localparam int unsigned MIN_SAMPLE_BITS = 4;
endpackage

// File: rtl/ssp_sync_fifo.sv
`timescale 1ns/1ps
module ssp_sync_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    level,
   output logic             full,
   output logic             empty
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("ssp_sync_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = empty ? '0 : store[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ssp_watermark.sv
`timescale 1ns/1ps
module ssp_watermark
   import ssp_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter wm_dir_e     DIR   = WM_REFILL,
   localparam int unsigned TW   = $clog2(DEPTH),
   localparam int unsigned CW   = TW + 1
) (
   input  logic [CW-1:0] level,
   input  logic [TW-1:0] thresh_code,
   input  logic          irq_en,
   input  logic          dma_en,
   output logic          irq,
   output logic          dma_req
);
   logic [CW-1:0] thr;
   logic          hit;

   // Code zero stands for the full depth.
   assign thr = (thresh_code == '0) ? CW'(DEPTH) : {1'b0, thresh_code};

   generate
      if (DIR == WM_REFILL) begin : g_refill
         assign hit = (level <= thr);
      end else begin : g_drain
         assign hit = (level >= thr);
      end
   endgenerate

   assign irq     = hit & irq_en;
   assign dma_req = hit & dma_en;
endmodule

// File: rtl/ssp_fifo_bus_if.sv
`timescale 1ns/1ps
module ssp_fifo_bus_if
   import ssp_fifo_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned SIZE_W = 6,
   localparam int unsigned TW    = $clog2(DEPTH),
   localparam int unsigned CW    = TW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [SIZE_W-1:0] cfg_sample_bits,
   input  logic [TW-1:0]     cfg_tx_thresh,
   input  logic [TW-1:0]     cfg_rx_thresh,
   input  logic              cfg_tx_irq_en,
   input  logic              cfg_tx_dma_en,
   input  logic              cfg_rx_irq_en,
   input  logic              cfg_rx_dma_en,
   input  logic              err_clr,
   input  logic              ser_pop,
   output logic [DATA_W-1:0] ser_data,
   input  logic              des_push,
   input  logic [DATA_W-1:0] des_data,
   output logic              tx_irq,
   output logic              tx_dma_req,
   output logic              rx_irq,
   output logic              rx_dma_req,
   output logic [CW-1:0]     tx_level,
   output logic [CW-1:0]     rx_level,
   output logic              tx_not_full,
   output logic              tx_not_empty,
   output logic              rx_not_full,
   output logic              rx_not_empty,
   output logic              tx_overrun,
   output logic              rx_underrun
);
   generate
      if ((1 << SIZE_W) <= DATA_W) begin : g_bad_size_w
         $error("ssp_fifo_bus_if: SIZE_W too narrow to encode DATA_W");
      end
      if (DATA_W < MIN_SAMPLE_BITS) begin : g_bad_data_w
         $error("ssp_fifo_bus_if: DATA_W below minimum sample size");
      end
   endgenerate

   // Sample-size mask, clamped to the legal range.
   logic [DATA_W-1:0] size_mask;
   int unsigned       eff_bits;

   always_comb begin
      if (int'(cfg_sample_bits) < int'(MIN_SAMPLE_BITS)) eff_bits = MIN_SAMPLE_BITS;
      else if (int'(cfg_sample_bits) > int'(DATA_W))     eff_bits = DATA_W;
      else                                               eff_bits = int'(cfg_sample_bits);
      for (int i = 0; i < int'(DATA_W); i++) size_mask[i] = (i < int'(eff_bits));
   end

   // Transmit queue: bus writes in, serializer out.
   logic              tx_full, tx_empty;
   ssp_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) tx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (bus_wr_en),
      .push_data(bus_wdata & size_mask),
      .pop      (ser_pop),
      .head     (ser_data),
      .level    (tx_level),
      .full     (tx_full),
      .empty    (tx_empty)
   );

   // Receive queue: deserializer in, bus reads out.
   logic              rx_full, rx_empty;
   logic [DATA_W-1:0] rx_head;
   ssp_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (des_push),
      .push_data(des_data),
      .pop      (bus_rd_en),
      .head     (rx_head),
      .level    (rx_level),
      .full     (rx_full),
      .empty    (rx_empty)
   );

   assign bus_rdata    = rx_head & size_mask;
   assign tx_not_full  = ~tx_full;
   assign tx_not_empty = ~tx_empty;
   assign rx_not_full  = ~rx_full;
   assign rx_not_empty = ~rx_empty;

   ssp_watermark #(.DEPTH(DEPTH), .DIR(WM_REFILL)) tx_wm (
      .level      (tx_level),
      .thresh_code(cfg_tx_thresh),
      .irq_en     (cfg_tx_irq_en),
      .dma_en     (cfg_tx_dma_en),
      .irq        (tx_irq),
      .dma_req    (tx_dma_req)
   );

   ssp_watermark #(.DEPTH(DEPTH), .DIR(WM_DRAIN)) rx_wm (
      .level      (rx_level),
      .thresh_code(cfg_rx_thresh),
      .irq_en     (cfg_rx_irq_en),
      .dma_en     (cfg_rx_dma_en),
      .irq        (rx_irq),
      .dma_req    (rx_dma_req)
   );

   // Sticky error flags; a new event wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_overrun  <= 1'b0;
         rx_underrun <= 1'b0;
      end else begin
         if (bus_wr_en && tx_full)       tx_overrun  <= 1'b1;
         else if (err_clr)               tx_overrun  <= 1'b0;
         if (bus_rd_en && rx_empty)      rx_underrun <= 1'b1;
         else if (err_clr)               rx_underrun <= 1'b0;
      end
   end
endmodule

// File: rtl/ssp_fifo_bus_if_chk.sv
`timescale 1ns/1ps
module ssp_fifo_bus_if_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned SIZE_W = 6,
   localparam int unsigned TW    = $clog2(DEPTH),
   localparam int unsigned CW    = TW + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic              bus_rd_en,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [SIZE_W-1:0] cfg_sample_bits,
   input logic              cfg_tx_irq_en,
   input logic              cfg_tx_dma_en,
   input logic              cfg_rx_irq_en,
   input logic              cfg_rx_dma_en,
   input logic              ser_pop,
   input logic              des_push,
   input logic              tx_irq,
   input logic              tx_dma_req,
   input logic              rx_irq,
   input logic              rx_dma_req,
   input logic [CW-1:0]     tx_level,
   input logic [CW-1:0]     rx_level,
   input logic              tx_not_full,
   input logic              rx_not_full,
   input logic              rx_not_empty,
   input logic              tx_overrun,
   input logic              rx_underrun
);
   assert_level_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

   assert_rd_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && cfg_sample_bits >= SIZE_W'(4) && cfg_sample_bits < SIZE_W'(DATA_W))
      |-> ((bus_rdata >> cfg_sample_bits) == '0));

   assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !tx_not_full) |=> tx_overrun);

   assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !tx_not_full && !ser_pop) |=> (tx_level == $past(tx_level)));

   assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !rx_not_empty) |-> (bus_rdata == '0));

   assert_underrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !rx_not_empty) |=> rx_underrun);

   assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq |-> cfg_tx_irq_en) and (tx_dma_req |-> cfg_tx_dma_en));

   assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq |-> cfg_rx_irq_en) and (rx_dma_req |-> cfg_rx_dma_en));

   assert_rx_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (des_push && rx_not_full && !bus_rd_en) |=> (rx_level == CW'($past(rx_level) + 1'b1)));
endmodule

bind ssp_fifo_bus_if ssp_fifo_bus_if_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .SIZE_W(SIZE_W)
) chk_i (.*);

// File: tb/ssp_fifo_bus_if_tb_top.sv
`timescale 1ns/1ps
module ssp_fifo_bus_if_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [5:0]  cfg_sample_bits = 6'd32;
   logic [3:0]  cfg_tx_thresh = 4'd4, cfg_rx_thresh = 4'd4;
   logic        cfg_tx_irq_en = 1'b1, cfg_tx_dma_en = 1'b0;
   logic        cfg_rx_irq_en = 1'b1, cfg_rx_dma_en = 1'b0;
   logic        err_clr = 1'b0, ser_pop = 1'b0, des_push = 1'b0;
   logic [31:0] ser_data, des_data = '0;
   logic        tx_irq, tx_dma_req, rx_irq, rx_dma_req;
   logic [4:0]  tx_level, rx_level;
   logic        tx_not_full, tx_not_empty, rx_not_full, rx_not_empty;
   logic        tx_overrun, rx_underrun;

   always #2.5 clk = ~clk;

   ssp_fifo_bus_if dut_i (.*);

   int          n_cmp = 0, n_bad = 0;
   int          mdl_tx = 0, mdl_rx = 0;
   logic [31:0] tx_sb [$];
   logic [31:0] rx_sb [$];

   function automatic logic [31:0] exp_mask(input int bits);
      int eff = (bits < 4) ? 4 : (bits > 32) ? 32 : bits;
      logic [31:0] m = '0;
      for (int i = 0; i < eff; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: bus write; scoreboard entry when room is available.
   task automatic bus_write(input logic [31:0] d);
      bus_wr_en = 1'b1; bus_wdata = d;
      if (mdl_tx < 16) begin
         tx_sb.push_back(d & exp_mask(int'(cfg_sample_bits)));
         mdl_tx++;
      end
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   // Monitor: serializer pops, compared against the scoreboard.
   task automatic tx_drain(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         ser_pop = 1'b1;
         #1;
         check(req, ser_data, tx_sb.pop_front());
         mdl_tx--;
         @(negedge clk);
      end
      ser_pop = 1'b0;
   endtask

   task automatic des_in(input logic [31:0] d);
      des_push = 1'b1; des_data = d;
      if (mdl_rx < 16) begin
         rx_sb.push_back(d);
         mdl_rx++;
      end
      @(negedge clk);
      des_push = 1'b0;
   endtask

   task automatic bus_read(input string req);
      logic [31:0] exp;
      bus_rd_en = 1'b1;
      #1;
      if (mdl_rx > 0) begin
         exp = rx_sb.pop_front() & exp_mask(int'(cfg_sample_bits));
         mdl_rx--;
      end else exp = '0;
      check(req, bus_rdata, exp);
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check("R9 tx_level", 32'(tx_level), 0);
      check("R9 rx_level", 32'(rx_level), 0);
      check("R9 flags", {30'b0, tx_overrun, rx_underrun}, 0);
      check("R9 rdata", bus_rdata, 0);
      check("R9 ser_data", ser_data, 0);
      check("R1 empty status", {28'b0, tx_not_full, tx_not_empty, rx_not_full, rx_not_empty}, 32'b1010);
      check("R6 tx_irq at level 0", 32'(tx_irq), 1);
      check("R6 tx_dma gated", 32'(tx_dma_req), 0);

      // R2 write masking, several sample sizes and clamping
      cfg_sample_bits = 6'd8;  bus_write(32'hDEADBEEF);
      cfg_sample_bits = 6'd12; bus_write(32'h12345678);
      cfg_sample_bits = 6'd3;  bus_write(32'hFFFFFFFF);
      cfg_sample_bits = 6'd40; bus_write(32'hCAFEF00D);
      cfg_sample_bits = 6'd32; bus_write(32'h11111111);
      check("R1 tx_level 5", 32'(tx_level), 5);
      check("R6 tx_irq above thresh", 32'(tx_irq), 0);
      cfg_tx_dma_en = 1'b1;
      tx_drain(1, "R2 masked word");
      check("R6 tx_irq at thresh", 32'(tx_irq), 1);
      check("R6 tx_dma at thresh", 32'(tx_dma_req), 1);
      tx_drain(4, "R2 R8 masked order");
      check("R1 tx drained", 32'(tx_not_empty), 0);

      // R4 overrun on full transmit queue
      for (int i = 0; i < 16; i++) bus_write(32'hA000_0000 + i);
      check("R1 tx full level", 32'(tx_level), 16);
      check("R1 tx_not_full", 32'(tx_not_full), 0);
      cfg_tx_thresh = 4'd0;
      #1 check("R6 code0 means 16", 32'(tx_dma_req), 1);
      cfg_tx_thresh = 4'd4;
      #1 check("R6 level16 above 4", 32'(tx_dma_req), 0);
      bus_write(32'h0000_0BAD);
      check("R4 level held", 32'(tx_level), 16);
      check("R4 overrun set", 32'(tx_overrun), 1);
      @(negedge clk);
      check("R4 overrun sticky", 32'(tx_overrun), 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      check("R4 overrun cleared", 32'(tx_overrun), 0);
      tx_drain(16, "R4 R8 dropped word absent");
      ser_pop = 1'b1; @(negedge clk); ser_pop = 1'b0;
      check("R8 pop empty tx", 32'(tx_level), 0);

      // R7 receive watermark, R3 read masking
      cfg_rx_thresh = 4'd3;
      des_in(32'h89ABCDEF); des_in(32'h01234567);
      check("R7 rx below thresh", 32'(rx_irq), 0);
      des_in(32'hFEDCBA98);
      check("R7 rx_irq at thresh", 32'(rx_irq), 1);
      check("R7 rx_dma gated", 32'(rx_dma_req), 0);
      check("R1 rx_level 3", 32'(rx_level), 3);
      cfg_sample_bits = 6'd8;
      bus_read("R3 masked read");
      cfg_sample_bits = 6'd20;
      bus_read("R3 masked read");
      bus_read("R3 masked read");
      check("R7 rx empty no req", 32'(rx_irq), 0);
      bus_read("R5 empty read zero");
      check("R5 underrun set", 32'(rx_underrun), 1);
      check("R5 rx_level held", 32'(rx_level), 0);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      check("R5 underrun cleared", 32'(rx_underrun), 0);

      // R8 receive full, code 0 threshold
      cfg_sample_bits = 6'd32;
      cfg_rx_thresh = 4'd0;
      for (int i = 0; i < 15; i++) des_in(32'h5000_0000 + i);
      check("R7 code0 at 15", 32'(rx_irq), 0);
      des_in(32'h5000_000F);
      check("R7 code0 at 16", 32'(rx_irq), 1);
      cfg_rx_dma_en = 1'b1;
      #1 check("R7 rx_dma enabled", 32'(rx_dma_req), 1);
      des_in(32'h5EEE_EEEE);
      check("R8 rx push full dropped", 32'(rx_level), 16);
      check("R1 rx_not_full", 32'(rx_not_full), 0);

      // R10 simultaneous read and write
      bus_wr_en = 1'b1; bus_wdata = 32'h0000_0077;
      tx_sb.push_back(32'h77); mdl_tx++;
      bus_read("R10 read during write");
      bus_wr_en = 1'b0;
      check("R10 tx_level", 32'(tx_level), 1);
      check("R10 rx_level", 32'(rx_level), 15);

      // R8 push and pop same cycle on receive queue
      des_push = 1'b1; des_data = 32'h6666_6666;
      rx_sb.push_back(32'h6666_6666); mdl_rx++;
      bus_read("R8 read during push");
      des_push = 1'b0;
      check("R8 level unchanged", 32'(rx_level), 15);
      for (int i = 0; i < 15; i++) bus_read("R8 rx order");
      tx_drain(1, "R10 written word");
      check("R1 final levels", {22'b0, tx_level, rx_level}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule